// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block decides, once per clock update, whether the current calendar time has reached a programmed alarm. The update sequencer pulses a compare strobe. On that strobe the unit checks four time fields against four alarm settings: seconds, minutes, hours and day of month. A field is left out of the check when its alarm setting holds the wildcard code. A full match sets a sticky alarm flag. When the alarm enable is high, the flag also drives an interrupt request.

The wildcards set the alarm rate:

| Alarm fields in use | Rate |
|---|---|
| Day, hours, minutes and seconds | Monthly |
| Hours, minutes and seconds (day is a wildcard) | Daily |
| Minutes and seconds (day and hours are wildcards) | Hourly |
| Seconds only | Every minute |
| None (all four are wildcards) | Every second |

The flag stays set until software reads the flag register, which the host signals with a read strobe. Time and alarm bytes are compared as raw bit patterns. Whether they hold BCD or binary is left to the rest of the clock.

Top module: `rtc_alarm_match`

## Requirements
- R1: While reset is asserted, and after it is released, `alm_flag` and `irq` are 0.
- R2: The comparison only takes effect in a cycle where `cmp_stb` is 1. A matching time without the strobe leaves `alm_flag` unchanged.
- R3: When `cmp_stb` is 1 and every non-wildcard field matches, `alm_flag` is 1 from the next clock edge on.
- R4: When `cmp_stb` is 1 and any non-wildcard field differs, `alm_flag` keeps its previous value.
- R5: A seconds, minutes or hours alarm byte is a wildcard when both bits [7:6] are 1 (for example 0xC0 or 0xFF). A byte with only bit 7 set, such as 0x80, is still compared.
- R6: The day alarm is a 6-bit field. The value 0 in that field makes it a wildcard. Any other value is zero-extended to 8 bits and compared with the full 8-bit current day.
- R7: `irq` is 1 exactly when `alm_flag` is 1 and `alm_en` is 1.
- R8: Once set, `alm_flag` stays 1 until a cycle with `flag_rd` = 1. It reads 0 after the clock edge that ends that cycle.
- R9: If a matching strobe and `flag_rd` fall in the same cycle, the set wins and `alm_flag` remains 1.
- R10: Fields are compared as raw 8-bit values with no number conversion. For example, an alarm of 0x0A does not match a current value of 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_stb | input | 1 | Compare strobe from the update sequencer |
| alm_en | input | 1 | Alarm interrupt enable |
| flag_rd | input | 1 | Flag register read strobe; clears the flag |
| cur_sec | input | TW | Current seconds |
| cur_min | input | TW | Current minutes |
| cur_hour | input | TW | Current hours |
| cur_day | input | TW | Current day of month |
| alm_sec | input | TW | Seconds alarm; wildcard when bits [7:6] are 11 |
| alm_min | input | TW | Minutes alarm; wildcard when bits [7:6] are 11 |
| alm_hour | input | TW | Hours alarm; wildcard when bits [7:6] are 11 |
| alm_day | input | DW | Day alarm; wildcard when 0 |
| alm_flag | output | 1 | Sticky alarm event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit time fields (TW = 8) and a 6-bit day alarm (DW = 6).

These widths make the two wildcard encodings reachable: bits [7:6] of the time bytes, and the zero day code. They also bring in the zero-extension case, where the current day has bits set above the 6-bit alarm field.

A vector table covers every alarm rate, with both a matching and a mismatching time for each. Directed tests then cover the strobe gating, flag persistence, the clear on read, the set-versus-read collision and the enable gating of the interrupt.

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match #(
  parameter int TW = 8,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_stb,
  input  logic          alm_en,
  input  logic          flag_rd,
  input  logic [TW-1:0] cur_sec,
  input  logic [TW-1:0] cur_min,
  input  logic [TW-1:0] cur_hour,
  input  logic [TW-1:0] cur_day,
  input  logic [TW-1:0] alm_sec,
  input  logic [TW-1:0] alm_min,
  input  logic [TW-1:0] alm_hour,
  input  logic [DW-1:0] alm_day,
  output logic          alm_flag,
  output logic          irq
);

  localparam logic [1:0]    WILD = 2'b11;
  localparam logic [TW-1:0] DAY_ZEXT_PAD = '0;

  logic sec_ok, min_ok, hour_ok, day_ok, hit;
  logic flag_q;

  assign sec_ok  = (alm_sec[TW-1:TW-2]  == WILD) || (alm_sec  == cur_sec);
  assign min_ok  = (alm_min[TW-1:TW-2]  == WILD) || (alm_min  == cur_min);
  assign hour_ok = (alm_hour[TW-1:TW-2] == WILD) || (alm_hour == cur_hour);
  assign day_ok  = (alm_day == '0) ||
                   (cur_day == (DAY_ZEXT_PAD | TW'(alm_day)));
  assign hit     = sec_ok && min_ok && hour_ok && day_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (cmp_stb && hit)   flag_q <= 1'b1;
    else if (flag_rd)          flag_q <= 1'b0;
  end

  assign alm_flag = flag_q;
  assign irq      = flag_q && alm_en;

  assert_set_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_stb && hit) |=> alm_flag);

  assert_hold_without_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmp_stb && hit) && !flag_rd) |=> $stable(alm_flag));

  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !(cmp_stb && hit)) |=> !alm_flag);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alm_flag && alm_en));

  assert_set_beats_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_stb && hit && flag_rd) |=> alm_flag);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> !alm_flag);

endmodule

// File: tb/test_rtc_alarm_match.sv
`timescale 1ns/1ps
module test_rtc_alarm_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_stb = 1'b0, alm_en = 1'b0, flag_rd = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0;
  logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0;
  logic [5:0] alm_day = '0;
  logic alm_flag, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .cmp_stb(cmp_stb), .alm_en(alm_en), .flag_rd(flag_rd),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
    .alm_flag(alm_flag), .irq(irq));

  // {cur_sec, cur_min, cur_hour, cur_day, alm_sec, alm_min, alm_hour, alm_day[5:0], expect}
  localparam int NV = 14;
  localparam logic [62:0] VEC [NV] = '{
    {8'h30, 8'h45, 8'h12, 8'h15, 8'h30, 8'h45, 8'h12, 6'h15, 1'b1}, // R3 monthly
    {8'h31, 8'h45, 8'h12, 8'h15, 8'h30, 8'h45, 8'h12, 6'h15, 1'b0}, // R4 sec differs
    {8'h30, 8'h45, 8'h12, 8'h16, 8'h30, 8'h45, 8'h12, 6'h15, 1'b0}, // R4 day differs
    {8'h30, 8'h45, 8'h12, 8'h28, 8'h30, 8'h45, 8'h12, 6'h00, 1'b1}, // R6 daily
    {8'h30, 8'h45, 8'h13, 8'h28, 8'h30, 8'h45, 8'h12, 6'h00, 1'b0}, // R4 daily hour differs
    {8'h30, 8'h45, 8'h23, 8'h09, 8'h30, 8'h45, 8'hC0, 6'h00, 1'b1}, // R5 hourly
    {8'h30, 8'h45, 8'h07, 8'h09, 8'h30, 8'h45, 8'hFF, 6'h00, 1'b1}, // R5 0xFF wildcard
    {8'h30, 8'h46, 8'h07, 8'h09, 8'h30, 8'h45, 8'hC0, 6'h00, 1'b0}, // R4 hourly min differs
    {8'h30, 8'h45, 8'h23, 8'h09, 8'h30, 8'h45, 8'h80, 6'h00, 1'b0}, // R5 0x80 compared
    {8'h30, 8'h11, 8'h23, 8'h09, 8'h30, 8'hC5, 8'hC0, 6'h00, 1'b1}, // R5 per-minute
    {8'h59, 8'h11, 8'h23, 8'h09, 8'hC0, 8'hC5, 8'hC0, 6'h00, 1'b1}, // R5 per-second
    {8'h10, 8'h00, 8'h00, 8'h01, 8'h0A, 8'hC0, 8'hC0, 6'h00, 1'b0}, // R10 raw compare
    {8'h30, 8'h45, 8'h12, 8'h55, 8'h30, 8'h45, 8'h12, 6'h15, 1'b0}, // R6 zero-extend
    {8'h3F, 8'h45, 8'h12, 8'h15, 8'hC0, 8'h45, 8'h12, 6'h15, 1'b1}  // R5 sec wild only
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic load(input logic [62:0] v);
    {cur_sec, cur_min, cur_hour, cur_day, alm_sec, alm_min, alm_hour, alm_day} = v[62:1];
  endtask

  task automatic strobe();
    cmp_stb = 1'b1; @(negedge clk); cmp_stb = 1'b0;
  endtask

  task automatic clear_flag();
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    alm_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", alm_flag, 1'b0);
    check("R1", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", alm_flag, 1'b0);

    for (int k = 0; k < NV; k++) begin
      load(VEC[k]);
      strobe();
      check($sformatf("vector %0d", k), alm_flag, VEC[k][0]);
      clear_flag();
    end

    // R2: matching inputs without strobe
    load(VEC[0]);
    repeat (4) @(negedge clk);
    check("R2", alm_flag, 1'b0);

    // R8: flag persists, survives a mismatching strobe, clears on read
    strobe();
    load(VEC[1]);
    repeat (3) @(negedge clk);
    check("R8", alm_flag, 1'b1);
    strobe();
    check("R8", alm_flag, 1'b1);
    flag_rd = 1'b1;
    #1 check("R8", alm_flag, 1'b1);
    @(negedge clk); flag_rd = 1'b0;
    check("R8", alm_flag, 1'b0);

    // R7: irq follows flag and enable
    load(VEC[0]);
    alm_en = 1'b0;
    strobe();
    check("R7", irq, 1'b0);
    alm_en = 1'b1; #1;
    check("R7", irq, 1'b1);
    clear_flag();
    check("R7", irq, 1'b0);

    // R9: matching strobe and read in the same cycle
    cmp_stb = 1'b1; flag_rd = 1'b1;
    @(negedge clk); cmp_stb = 1'b0; flag_rd = 1'b0;
    check("R9", alm_flag, 1'b1);
    clear_flag();

    // R1: reset clears a set flag
    strobe();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", alm_flag, 1'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule